// File: doc/BRIEF.md
# CAN Message Handler with Masked Acceptance Filtering

This block sits between a CAN protocol engine and the processor. It keeps a bank of message objects. Each object holds an identifier, a per-object mask, a data length code, eight data bytes and a few status flags. When the protocol engine delivers a received frame, every object is compared in parallel against the frame identifier under its own mask. The frame is written into the lowest-numbered matching receive object. The handler also picks the lowest-numbered object with a pending transmit request and presents its contents to the engine until the engine reports completion. Every stored frame and every finished transmission raises a per-object interrupt flag, and these flags are combined into a single interrupt line.

The processor reaches every object field, and a global status word, through one flat register port. The address is `{object index, field select}`. Reads are combinational and writes take effect on the clock edge. A received frame written in the same cycle as a processor write to the same object takes precedence over it.

Top module: `can_msg_handler`

## Requirements
- R1: After reset, no object is valid, every object field reads as zero, and `tx_req`, `irq` and `rx_hit` are low.
- R2: Field select (low 3 address bits): 0 = config, 1 = identifier [28:0], 2 = mask [28:0], 3 = data bytes 0..3 (byte 0 in bits 7:0), 4 = data bytes 4..7, 5..7 = global status. Config bits: 0 valid, 1 direction (1 = transmit), 2 extended-ID flag, 3 transmit request, 7:4 DLC, 8 new-data, 9 message-lost, 10 interrupt pending. Fields 0..4 are writable and read back what was written.
- R3: A receive object accepts a frame when every identifier bit whose mask bit is 1 equals the stored bit. A mask bit of 0 is a don't-care. For standard frames only identifier bits [10:0] take part in the comparison.
- R4: An object accepts only if it is valid, set to receive direction, and its extended-ID flag equals that of the frame.
- R5: When several objects accept a frame, only the lowest-indexed one receives it.
- R6: One cycle after `rx_valid`, `rx_hit` pulses with `rx_obj` set to the receiving object. That object now holds the frame's identifier, DLC and data, and its new-data flag is set.
- R7: If the receiving object's new-data flag was already set, its message-lost flag is set and `rx_lost` pulses together with `rx_hit`.
- R8: A frame that no object accepts produces no `rx_hit` and changes no object.
- R9: When idle, the handler latches the lowest-indexed valid transmit object whose request is set. It holds `tx_req`, `tx_obj` and that object's identifier, IDE, DLC and data steady until `tx_done`. It then clears the object's request and drops `tx_req` for at least one cycle.
- R10: Storing a frame or finishing a transmission sets that object's interrupt-pending flag. `irq` is high while any flag is set. Status reads give bit 8 = `irq` and bits 4:0 = the lowest pending object. The processor clears a flag by rewriting config.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 8 | {object index, field select} |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Combinational read data |
| rx_valid | input | 1 | Received frame strobe from the protocol engine |
| rx_ide | input | 1 | Received frame uses a 29-bit identifier |
| rx_id | input | 29 | Received identifier |
| rx_dlc | input | 4 | Received data length code |
| rx_data | input | 64 | Received data, byte 0 in bits 7:0 |
| rx_hit | output | 1 | Frame was stored (one-cycle pulse) |
| rx_obj | output | 5 | Object that stored it |
| rx_lost | output | 1 | Stored frame overwrote unread data |
| tx_req | output | 1 | Transmit request towards the engine |
| tx_obj | output | 5 | Object being transmitted |
| tx_ide | output | 1 | Its extended-ID flag |
| tx_id | output | 29 | Its identifier |
| tx_dlc | output | 4 | Its DLC |
| tx_data | output | 64 | Its data |
| tx_done | input | 1 | Engine finished sending the frame |
| irq | output | 1 | Module interrupt |

## Verification
The bench sets up overlapping receive filters, so that two objects accept the same standard identifier. A priority encoder that favoured the higher index would put that frame into the wrong object. It also sends an extended frame whose low bits equal a standard object's identifier, and a standard frame with stray upper identifier bits. A filter that ignored the IDE flag, or compared all 29 bits for standard frames, would mis-store or drop those frames. A second write to an unread object must raise message-lost. Transmit requests are posted while another transmission is in flight, and they must then go out lowest index first. An arbiter that re-chose objects mid-frame or ignored order would show a changing `tx_obj` or the wrong sequence.

// File: rtl/can_mh_pkg.sv
package can_mh_pkg;
  localparam int ID_W  = 29;
  localparam int STD_W = 11;

  typedef struct packed {
    logic            valid;
    logic            dir;
    logic            ide;
    logic            txrqst;
    logic            newdat;
    logic            msglst;
    logic            intpnd;
    logic [3:0]      dlc;
    logic [ID_W-1:0] id;
    logic [ID_W-1:0] mask;
    logic [63:0]     data;
  } obj_t;

  typedef enum logic [2:0] {
    F_CFG  = 3'd0,
    F_ID   = 3'd1,
    F_MASK = 3'd2,
    F_DLO  = 3'd3,
    F_DHI  = 3'd4
  } fsel_e;

  // masked identifier compare; standard frames use only the low STD_W bits
  function automatic logic id_hit(input logic ide, input logic [ID_W-1:0] a,
                                  input logic [ID_W-1:0] b, input logic [ID_W-1:0] m);
    logic [ID_W-1:0] width_m;
    width_m = ide ? {ID_W{1'b1}} : ID_W'({STD_W{1'b1}});
    return ((a ^ b) & m & width_m) == '0;
  endfunction

  function automatic logic [31:0] cfg_pack(input obj_t o);
    return {21'd0, o.intpnd, o.msglst, o.newdat, o.dlc, o.txrqst, o.ide, o.dir, o.valid};
  endfunction
endpackage

// File: rtl/can_mh_prio.sv
module can_mh_prio #(
  parameter  int N  = 32,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  logic [N-1:0] grant;

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
    any   = |req;
    grant = any ? (N'(1) << idx) : '0;
  end

  always_comb begin
    // R5
    grant_onehot_chk: assert ($onehot0(grant));
    // R5
    lowest_wins_chk: assert (!any || (req & grant) == grant);
  end
endmodule

// File: rtl/can_mh_filter.sv
module can_mh_filter import can_mh_pkg::*; #(
  parameter int NOBJ = 32
) (
  input  obj_t            objs [NOBJ],
  input  logic            rx_ide,
  input  logic [ID_W-1:0] rx_id,
  output logic [NOBJ-1:0] hit
);
  for (genvar g = 0; g < NOBJ; g++) begin : g_cmp
    assign hit[g] = objs[g].valid && !objs[g].dir && (objs[g].ide == rx_ide) &&
                    id_hit(rx_ide, rx_id, objs[g].id, objs[g].mask);
  end
endmodule

// File: rtl/can_mh_objram.sv
module can_mh_objram import can_mh_pkg::*; #(
  parameter  int NOBJ = 32,
  localparam int OW   = $clog2(NOBJ)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [OW-1:0]   cpu_obj,
  input  logic [2:0]      cpu_sel,
  input  logic [31:0]     cpu_wdata,
  input  logic            rx_we,
  input  logic [OW-1:0]   rx_idx,
  input  logic [ID_W-1:0] rx_id,
  input  logic [3:0]      rx_dlc,
  input  logic [63:0]     rx_data,
  input  logic            tx_clr,
  input  logic [OW-1:0]   tx_idx,
  output obj_t            objs [NOBJ]
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NOBJ; i++) objs[i] <= '0;
    end else begin
      if (cpu_we) begin
        case (cpu_sel)
          F_CFG: begin
            objs[cpu_obj].valid  <= cpu_wdata[0];
            objs[cpu_obj].dir    <= cpu_wdata[1];
            objs[cpu_obj].ide    <= cpu_wdata[2];
            objs[cpu_obj].txrqst <= cpu_wdata[3];
            objs[cpu_obj].dlc    <= cpu_wdata[7:4];
            objs[cpu_obj].newdat <= cpu_wdata[8];
            objs[cpu_obj].msglst <= cpu_wdata[9];
            objs[cpu_obj].intpnd <= cpu_wdata[10];
          end
          F_ID:    objs[cpu_obj].id         <= cpu_wdata[ID_W-1:0];
          F_MASK:  objs[cpu_obj].mask       <= cpu_wdata[ID_W-1:0];
          F_DLO:   objs[cpu_obj].data[31:0] <= cpu_wdata;
          F_DHI:   objs[cpu_obj].data[63:32] <= cpu_wdata;
          default: ;
        endcase
      end
      if (rx_we) begin
        objs[rx_idx].id     <= rx_id;
        objs[rx_idx].dlc    <= rx_dlc;
        objs[rx_idx].data   <= rx_data;
        objs[rx_idx].newdat <= 1'b1;
        objs[rx_idx].msglst <= objs[rx_idx].msglst | objs[rx_idx].newdat;
        objs[rx_idx].intpnd <= 1'b1;
      end
      if (tx_clr) begin
        objs[tx_idx].txrqst <= 1'b0;
        objs[tx_idx].intpnd <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/can_msg_handler.sv
module can_msg_handler import can_mh_pkg::*; #(
  parameter  int NOBJ = 32,
  localparam int OW   = $clog2(NOBJ),
  localparam int AW   = OW + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cpu_we,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [31:0]     cpu_wdata,
  output logic [31:0]     cpu_rdata,
  input  logic            rx_valid,
  input  logic            rx_ide,
  input  logic [ID_W-1:0] rx_id,
  input  logic [3:0]      rx_dlc,
  input  logic [63:0]     rx_data,
  output logic            rx_hit,
  output logic [OW-1:0]   rx_obj,
  output logic            rx_lost,
  output logic            tx_req,
  output logic [OW-1:0]   tx_obj,
  output logic            tx_ide,
  output logic [ID_W-1:0] tx_id,
  output logic [3:0]      tx_dlc,
  output logic [63:0]     tx_data,
  input  logic            tx_done,
  output logic            irq
);
  obj_t            objs [NOBJ];
  logic [NOBJ-1:0] acc_vec, pend_vec, int_vec;
  logic            acc_any, pend_any;
  logic [OW-1:0]   acc_idx, pend_idx, int_idx;
  logic            rx_store, tx_start, tx_finish;
  logic [OW-1:0]   cpu_obj;
  logic [2:0]      cpu_sel;

  assign cpu_obj = cpu_addr[AW-1:3];
  assign cpu_sel = cpu_addr[2:0];

  can_mh_filter #(.NOBJ(NOBJ)) u_filter (
    .objs(objs), .rx_ide(rx_ide), .rx_id(rx_id), .hit(acc_vec));

  for (genvar g = 0; g < NOBJ; g++) begin : g_vec
    assign pend_vec[g] = objs[g].valid && objs[g].dir && objs[g].txrqst;
    assign int_vec[g]  = objs[g].intpnd;
  end

  can_mh_prio #(.N(NOBJ)) u_rx_pri  (.req(acc_vec),  .any(acc_any),  .idx(acc_idx));
  can_mh_prio #(.N(NOBJ)) u_tx_pri  (.req(pend_vec), .any(pend_any), .idx(pend_idx));
  can_mh_prio #(.N(NOBJ)) u_irq_pri (.req(int_vec),  .any(irq),      .idx(int_idx));

  assign rx_store  = rx_valid && acc_any;
  assign tx_start  = !tx_req && pend_any;
  assign tx_finish = tx_req && tx_done;

  can_mh_objram #(.NOBJ(NOBJ)) u_ram (
    .clk(clk), .rst_n(rst_n),
    .cpu_we(cpu_we), .cpu_obj(cpu_obj), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .rx_we(rx_store), .rx_idx(acc_idx), .rx_id(rx_id), .rx_dlc(rx_dlc), .rx_data(rx_data),
    .tx_clr(tx_finish), .tx_idx(tx_obj), .objs(objs));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_hit  <= 1'b0;
      rx_obj  <= '0;
      rx_lost <= 1'b0;
      tx_req  <= 1'b0;
      tx_obj  <= '0;
    end else begin
      rx_hit  <= rx_store;
      rx_lost <= rx_store && objs[acc_idx].newdat;
      if (rx_store) rx_obj <= acc_idx;
      if (tx_start) begin
        tx_req <= 1'b1;
        tx_obj <= pend_idx;
      end else if (tx_finish) begin
        tx_req <= 1'b0;
      end
    end
  end

  assign tx_ide  = objs[tx_obj].ide;
  assign tx_id   = objs[tx_obj].id;
  assign tx_dlc  = objs[tx_obj].dlc;
  assign tx_data = objs[tx_obj].data;

  always_comb begin
    case (cpu_sel)
      F_CFG:   cpu_rdata = cfg_pack(objs[cpu_obj]);
      F_ID:    cpu_rdata = 32'(objs[cpu_obj].id);
      F_MASK:  cpu_rdata = 32'(objs[cpu_obj].mask);
      F_DLO:   cpu_rdata = objs[cpu_obj].data[31:0];
      F_DHI:   cpu_rdata = objs[cpu_obj].data[63:32];
      default: cpu_rdata = (32'(irq) << 8) | 32'(int_idx);
    endcase
  end

  // R9
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && !tx_done |=> tx_req && $stable(tx_obj));
  // R9
  tx_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req && tx_done |=> !tx_req);
  // R10
  rx_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_hit |-> irq);
  // R8
  no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !acc_any |=> !rx_hit);
  // R7
  lost_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_lost |-> rx_hit);
endmodule

// File: tb/can_msg_handler_test.sv
`timescale 1ns/1ps
module can_msg_handler_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_we = 1'b0;
  logic [7:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        rx_valid = 1'b0, rx_ide = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_dlc = '0;
  logic [63:0] rx_data = '0;
  logic        rx_hit, rx_lost, tx_req, tx_ide, irq;
  logic [4:0]  rx_obj, tx_obj;
  logic [28:0] tx_id;
  logic [3:0]  tx_dlc;
  logic [63:0] tx_data;
  logic        tx_done = 1'b0;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  typedef struct { int obj; bit lost; string req; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  can_msg_handler uut (
    .clk(clk), .rst_n(rst_n), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .rx_valid(rx_valid), .rx_ide(rx_ide), .rx_id(rx_id), .rx_dlc(rx_dlc),
    .rx_data(rx_data), .rx_hit(rx_hit), .rx_obj(rx_obj), .rx_lost(rx_lost),
    .tx_req(tx_req), .tx_obj(tx_obj), .tx_ide(tx_ide), .tx_id(tx_id),
    .tx_dlc(tx_dlc), .tx_data(tx_data), .tx_done(tx_done), .irq(irq));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg(input bit v, input bit d, input bit x, input bit t,
                                      input int dl);
    return 32'(v) | (32'(d) << 1) | (32'(x) << 2) | (32'(t) << 3) | (32'(dl) << 4);
  endfunction

  task automatic wr(input int obj, input int sel, input logic [31:0] v);
    @(posedge clk); #1;
    cpu_addr = {obj[4:0], sel[2:0]}; cpu_wdata = v; cpu_we = 1'b1;
    @(posedge clk); #1;
    cpu_we = 1'b0;
  endtask

  task automatic rd(input int obj, input int sel, output logic [31:0] v);
    cpu_addr = {obj[4:0], sel[2:0]};
    #1 v = cpu_rdata;
  endtask

  // driver: pushes the expected result, then presents the frame
  task automatic send(input bit x, input logic [28:0] id, input int dl, input logic [63:0] d,
                      input int eobj, input bit elost, input string req);
    exp_t e;
    if (eobj >= 0) begin
      e.obj = eobj; e.lost = elost; e.req = req;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    rx_valid = 1'b1; rx_ide = x; rx_id = id; rx_dlc = dl[3:0]; rx_data = d;
    @(posedge clk); #1;
    rx_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rx_hit) begin
      if (sb.size() == 0) begin
        chk("R8 unexpected rx_hit", {59'd0, rx_obj}, 64'hFFFF);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk({e.req, " rx_obj"}, 64'(rx_obj), 64'(e.obj));
        chk({e.req, " rx_lost (R7)"}, 64'(rx_lost), 64'(e.lost));
      end
    end
  end

  task automatic wait_tx;
    for (int i = 0; i < 20 && !tx_req; i++) @(negedge clk);
  endtask

  task automatic finish_tx;
    @(posedge clk); #1 tx_done = 1'b1;
    @(posedge clk); #1 tx_done = 1'b0;
    chk("R9 tx_req drops after done", 64'(tx_req), 64'd0);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 tx_req", 64'(tx_req), 0);
    chk("R1 irq", 64'(irq), 0);
    chk("R1 rx_hit", 64'(rx_hit), 0);
    rd(2, 0, v); chk("R1 cfg zero", 64'(v), 0);
    rd(31, 1, v); chk("R1 id zero", 64'(v), 0);

    // receive objects
    wr(2, 1, 32'h123); wr(2, 2, 32'h7FF); wr(2, 0, cfg(1, 0, 0, 0, 0));
    wr(5, 1, 32'h120); wr(5, 2, 32'h7F0); wr(5, 0, cfg(1, 0, 0, 0, 0));
    wr(7, 1, 32'h1ABCDEF); wr(7, 2, 32'h1FFFFFFF); wr(7, 0, cfg(1, 0, 1, 0, 0));
    wr(11, 1, 32'h555); wr(11, 2, 32'h7FF);
    rd(5, 2, v); chk("R2 mask readback", 64'(v), 64'h7F0);
    rd(7, 0, v); chk("R2 cfg readback", 64'(v), 64'h5);

    // R5: objects 2 and 5 both accept 0x123
    send(0, 29'h123, 8, 64'h0807060504030201, 2, 0, "R5 lowest index");
    rd(2, 3, v); chk("R6 data lo", 64'(v), 64'h04030201);
    rd(2, 4, v); chk("R6 data hi", 64'(v), 64'h08070605);
    rd(2, 0, v); chk("R6 cfg after store", 64'(v), 64'h581);
    rd(2, 5, v); chk("R10 status", 64'(v), 64'h102);
    wr(2, 0, cfg(1, 0, 0, 0, 0));
    rd(2, 5, v); chk("R10 status cleared", 64'(v), 64'h0);
    chk("R10 irq low", 64'(irq), 0);

    send(0, 29'h12A, 3, 64'h77, 5, 0, "R3 masked match");
    rd(5, 1, v); chk("R6 id stored", 64'(v), 64'h12A);
    send(0, 29'h123, 2, 64'hAA55, 2, 0, "R6 fresh store");
    send(0, 29'h123, 2, 64'hBB66, 2, 1, "R7 overwrite");
    rd(2, 0, v); chk("R7 msglst bit", 64'(v[9]), 1);
    send(1, 29'h123, 4, 64'hDEAD, -1, 0, "R4 ide");
    rd(2, 3, v); chk("R8 data unchanged", 64'(v), 64'hBB66);
    send(1, 29'h1ABCDEF, 1, 64'h5A, 7, 0, "R4 extended match");
    send(0, 29'h555, 1, 64'h1, -1, 0, "R4 invalid");
    rd(11, 0, v); chk("R8 invalid untouched", 64'(v), 0);
    send(0, 29'h1F80123, 1, 64'h2, 2, 1, "R3 std ignores upper bits");

    // transmit
    wr(20, 1, 32'h7A); wr(20, 3, 32'hBEEF); wr(20, 0, cfg(1, 1, 0, 1, 2));
    wait_tx;
    chk("R9 first tx obj", 64'(tx_obj), 20);
    send(0, 29'h07A, 1, 64'h3, -1, 0, "R4 tx object never receives");
    wr(12, 1, 32'h300); wr(12, 3, 32'h11); wr(12, 0, cfg(1, 1, 0, 1, 1));
    wr(9, 1, 32'h1FFFFFFF); wr(9, 3, 32'h04030201); wr(9, 4, 32'h08070605);
    wr(9, 0, cfg(1, 1, 1, 1, 8));
    @(negedge clk);
    chk("R9 held obj", 64'(tx_obj), 20);
    chk("R9 held dlc", 64'(tx_dlc), 2);
    finish_tx;
    wait_tx;
    chk("R9 order lowest", 64'(tx_obj), 9);
    chk("R9 tx id", 64'(tx_id), 64'h1FFFFFFF);
    chk("R9 tx ide", 64'(tx_ide), 1);
    chk("R9 tx dlc", 64'(tx_dlc), 8);
    chk("R9 tx data", tx_data, 64'h0807060504030201);
    finish_tx;
    wait_tx;
    chk("R9 order next", 64'(tx_obj), 12);
    finish_tx;
    repeat (3) @(negedge clk);
    chk("R9 idle", 64'(tx_req), 0);
    rd(12, 0, v); chk("R10 tx intpnd, request cleared", 64'(v), 64'h413);
    chk("R8 scoreboard drained", 64'(sb.size()), 0);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule